// File: doc/BRIEF.md
# I2C Target with Own-Address Match

This block is the target end of a two-wire serial bus. It watches the clock and data lines through synchronisers running on the system clock. It detects start, stop and repeated-start conditions and shifts in a 7-bit address followed by a direction bit. When the address equals its own address, it acknowledges. It then moves data bytes between the bus and a local agent. In the write direction each received byte is handed over with a valid/ready pair. In the read direction the target asks for each byte with a ready input and signals that it has taken the byte with a one-cycle load pulse.

The target never drives a line high. Its two outputs are pull-low enables for the open-drain clock and data wires. When the local agent has not yet taken the last received byte, or has not yet supplied the next byte to send, the target holds the clock low. This pauses the controller until the agent catches up. A stop at any point releases both lines and makes the target idle. A repeated start at any point, even in the middle of a byte, discards the transfer and begins address reception again.

Top module: `i2c_target`

## Requirements
- R1: During and directly after reset, `scl_oe`, `sda_oe`, `rx_valid` and `tx_load` are 0.
- R2: A start (data falling while clock is high) begins reception of 8 bits sampled on clock rising edges, MSB first: 7 address bits then a direction bit where 1 means read and 0 means write.
- R3: If the 7 address bits equal `dev_addr`, the target pulls data low for the 9th (acknowledge) clock. Otherwise it leaves data released and ignores all traffic until the next start.
- R4: In write direction, each 8-bit byte appears on `rx_data` with `rx_valid` high after its 8th rising clock edge, and the target acknowledges it on the 9th clock.
- R5: In write direction, from the falling edge that ends the 8th bit, the target holds the clock low for as long as `rx_valid` is high. `rx_valid` drops only after a cycle with `rx_ready` high, and the clock is then released.
- R6: In read direction, before each byte the target holds the clock low until `tx_ready` is high. It then pulses `tx_load` for exactly one cycle, capturing `tx_data`, and presents the byte MSB first on data.
- R7: In read direction, a controller acknowledge (data low on the 9th clock) leads to a new byte request. A not-acknowledge (data high) makes the target release data and request no further byte until the next start.
- R8: A repeated start at any point, including within a byte, restarts address reception. The byte in progress is discarded, and the new address and direction are honoured.
- R9: A stop (data rising while clock is high) at any point makes the target idle, with both `scl_oe` and `sda_oe` at 0 from the cycle after the stop is seen.
- R10: `sda_oe` changes only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Own bus address compared with the received address |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_data | output | 8 | Last byte received in write direction |
| rx_valid | output | 1 | Received byte waiting for the local agent |
| rx_ready | input | 1 | Local agent takes the received byte |
| tx_data | input | 8 | Byte to send in read direction |
| tx_ready | input | 1 | `tx_data` holds a byte ready to send |
| tx_load | output | 1 | One-cycle pulse: `tx_data` has been captured |

## Verification
The bench uses the default two synchroniser stages and drives the bus with a clock half-period of 40 system cycles. This is well above the four-cycle reaction of the synchroniser, edge detector and output register. At that ratio every acknowledge, data change and stretch takes effect inside the low phase that called for it. The long half-period also leaves room for stretch windows of several hundred cycles, during which the bench observes the held clock. Two different values of `dev_addr` are applied, so that both matching and non-matching addresses are exercised. Repeated starts are placed both between bytes and within a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_WR_BITS,
        ST_WR_END,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_BITS,
        ST_RD_ACK
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                      input logic [ADDR_W-1:0] own);
        return frame[BYTE_W-1 -: ADDR_W] == own;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[gi]),
            .q   (synced[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // index 0 is the clock line, index 1 the data line
    always_comb begin
        evt.scl      = synced[0];
        evt.sda      = synced[1];
        evt.scl_rise = synced[0] & ~prev[0];
        evt.scl_fall = ~synced[0] & prev[0];
        evt.start    = prev[0] & synced[0] & prev[1] & ~synced[1];
        evt.stop     = prev[0] & synced[0] & ~prev[1] & synced[1];
    end
endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], shift_in};
    end
endmodule

// File: rtl/i2c_target.sv
module i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              tx_load
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_evt_t          evt;
    tgt_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              sda_n, scl_n, rxv_n, load_n;
    logic [BYTE_W-1:0] rxd_n;
    logic              hit_q, hit_n, rw_q, rw_n, nack_q, nack_n;
    logic              sh_load, sh_shift, sh_in;
    logic [BYTE_W-1:0] sh_q, sh_val, shifted;

    i2c_tgt_events #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_tgt_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .shift_in (sh_in),
        .q        (sh_q)
    );

    assign shifted = {sh_q[BYTE_W-2:0], evt.sda};
    // read bytes are loaded with the MSB already on the line
    assign sh_val  = {tx_data[BYTE_W-2:0], 1'b0};

    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        sda_n    = sda_oe;
        rxv_n    = rx_valid;
        rxd_n    = rx_data;
        load_n   = 1'b0;
        hit_n    = hit_q;
        rw_n     = rw_q;
        nack_n   = nack_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_in    = evt.sda;

        if (rx_valid && rx_ready) rxv_n = 1'b0;

        if (evt.stop) begin
            state_n = ST_IDLE;
            sda_n   = 1'b0;
        end else if (evt.start) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
            sda_n   = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: if (evt.scl_rise) begin
                    sh_shift = 1'b1;
                    if (cnt == LAST_BIT) begin
                        state_n = ST_ADDR_END;
                        hit_n   = addr_hit(shifted, dev_addr);
                        rw_n    = evt.sda;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_ADDR_END: if (evt.scl_fall) begin
                    if (hit_q) begin
                        state_n = ST_ADDR_ACK;
                        sda_n   = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                ST_ADDR_ACK: if (evt.scl_fall) begin
                    sda_n   = 1'b0;
                    cnt_n   = '0;
                    state_n = rw_q ? ST_RD_LOAD : ST_WR_BITS;
                end
                ST_WR_BITS: if (evt.scl_rise) begin
                    sh_shift = 1'b1;
                    if (cnt == LAST_BIT) begin
                        state_n = ST_WR_END;
                        rxd_n   = shifted;
                        rxv_n   = 1'b1;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_WR_END: if (evt.scl_fall) begin
                    state_n = ST_WR_ACK;
                    sda_n   = 1'b1;
                end
                ST_WR_ACK: if (evt.scl_fall) begin
                    state_n = ST_WR_BITS;
                    sda_n   = 1'b0;
                    cnt_n   = '0;
                end
                ST_RD_LOAD: if (tx_ready) begin
                    sh_load = 1'b1;
                    load_n  = 1'b1;
                    sda_n   = ~tx_data[BYTE_W-1];
                    cnt_n   = '0;
                    state_n = ST_RD_BITS;
                end
                ST_RD_BITS: if (evt.scl_fall) begin
                    if (cnt == LAST_BIT) begin
                        sda_n   = 1'b0;
                        state_n = ST_RD_ACK;
                    end else begin
                        sda_n    = ~sh_q[BYTE_W-1];
                        sh_shift = 1'b1;
                        sh_in    = 1'b0;
                        cnt_n    = cnt + CNT_W'(1);
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) nack_n = evt.sda;
                    if (evt.scl_fall) state_n = nack_q ? ST_IDLE : ST_RD_LOAD;
                end
                default: state_n = ST_IDLE;
            endcase
        end

        scl_n = (state_n == ST_RD_LOAD) || (state_n == ST_WR_ACK && rxv_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            scl_oe   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            tx_load  <= 1'b0;
            hit_q    <= 1'b0;
            rw_q     <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            sda_oe   <= sda_n;
            scl_oe   <= scl_n;
            rx_valid <= rxv_n;
            rx_data  <= rxd_n;
            tx_load  <= load_n;
            hit_q    <= hit_n;
            rw_q     <= rw_n;
            nack_q   <= nack_n;
        end
    end

    // R10: data output frozen across a synchronised clock high phase
    assert_sda_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (evt.scl && $past(evt.scl)) |-> $stable(sda_oe));

    // R6: load strobe lasts one cycle and follows a ready local side
    assert_load_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);
    assert_load_ready_R6: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> $past(tx_ready));

    // R5: a received byte is dropped only through the handshake
    assert_rx_consume_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_valid) |-> $past(rx_ready));
    assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && rx_valid && !rx_ready && !evt.stop && !evt.start) |=> scl_oe);

    // R9: stop releases both lines
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
        $past(evt.stop) |-> (!sda_oe && !scl_oe));
endmodule

// File: tb/sim_i2c_target.sv
module sim_i2c_target;
    localparam int HP = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] dev_addr;
    logic       scl_drv = 1'b1, sda_drv = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       tx_load;
    logic       tx_en;

    int n_checks = 0;
    int n_err    = 0;
    int viol     = 0;
    int tx_wr    = 0;
    int tx_rd    = 0;
    bit done     = 0;
    logic [7:0] tx_mem [16];
    logic [7:0] exp_rx [$];

    always #5 clk = ~clk;

    assign scl_bus  = scl_drv & ~scl_oe;
    assign sda_bus  = sda_drv & ~sda_oe;
    assign tx_ready = tx_en && (tx_rd < tx_wr);
    assign tx_data  = tx_mem[tx_rd & 15];

    i2c_target u0 (
        .clk(clk), .rst(rst), .dev_addr(dev_addr),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_load(tx_load)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for received bytes (R4)
    always @(negedge clk) begin
        if (!rst && rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) check_eq("R3 unexpected rx byte", {24'd0, rx_data}, 32'hFFFF);
            else check_eq("R4 rx byte", {24'd0, rx_data}, {24'd0, exp_rx.pop_front()});
        end
    end

    // local transmit side consumes its buffer on each load pulse
    always @(negedge clk) if (!rst && tx_load) tx_rd++;

    // R10 bus-level monitor
    logic scl_prev = 1'b1, sda_oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_bus && scl_prev && sda_oe != sda_oe_prev) viol++;
        scl_prev    <= scl_bus;
        sda_oe_prev <= sda_oe;
    end

    task automatic half(); repeat (HP) @(negedge clk); endtask
    task automatic wait_scl_high(); while (!scl_bus) @(negedge clk); endtask

    task automatic bus_start();
        sda_drv = 1'b1; half();
        scl_drv = 1'b1; wait_scl_high(); half();
        sda_drv = 1'b0; half();
        scl_drv = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; half();
        scl_drv = 1'b1; wait_scl_high(); half();
        sda_drv = 1'b1; half();
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_drv = b; half();
        scl_drv = 1'b1; wait_scl_high();
        repeat (HP/2) @(negedge clk);
        r = sda_bus;
        repeat (HP/2) @(negedge clk);
        scl_drv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
        clock_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            d[i] = r;
        end
        clock_bit(nack, r);
    endtask

    // driver: queue the expected byte, then write it
    task automatic write_exp(input logic [7:0] d, input string tag);
        logic ack;
        exp_rx.push_back(d);
        send_byte(d, ack);
        check_eq(tag, {31'd0, ack}, 32'd0);
    endtask

    task automatic tx_push(input logic [7:0] v);
        tx_mem[tx_wr & 15] = v;
        tx_wr++;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        logic       ack, r;
        logic [7:0] d;
        dev_addr = 7'h5A; rx_ready = 1'b1; tx_en = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R1 scl_oe in reset", {31'd0, scl_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 scl_oe", {31'd0, scl_oe}, 0);
        check_eq("R1 sda_oe", {31'd0, sda_oe}, 0);
        check_eq("R1 rx_valid", {31'd0, rx_valid}, 0);
        check_eq("R1 tx_load", {31'd0, tx_load}, 0);

        // plain write, two bytes
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check_eq("R2 address+write acked", {31'd0, ack}, 0);
        write_exp(8'hA5, "R4 ack byte 1");
        write_exp(8'h3C, "R4 ack byte 2");
        bus_stop();
        check_eq("R9 sda released", {31'd0, sda_oe}, 0);
        check_eq("R9 scl released", {31'd0, scl_oe}, 0);

        // foreign address
        bus_start();
        send_byte({7'h5B, 1'b0}, ack);
        check_eq("R3 mismatch nack", {31'd0, ack}, 1);
        send_byte(8'h77, ack);
        check_eq("R3 ignored byte nack", {31'd0, ack}, 1);
        bus_stop();

        // write with stretch
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        rx_ready = 1'b0;
        exp_rx.push_back(8'hC3);
        for (int i = 7; i >= 0; i--) clock_bit(d[0] ^ d[0] ^ ((8'hC3 >> i) & 1'b1), r);
        sda_drv = 1'b1; half();
        scl_drv = 1'b1;
        repeat (200) @(negedge clk);
        check_eq("R5 clock held low", {31'd0, scl_bus}, 0);
        check_eq("R4 rx_valid pending", {31'd0, rx_valid}, 1);
        check_eq("R4 rx_data value", {24'd0, rx_data}, 32'hC3);
        @(posedge clk); #2 rx_ready = 1'b1;
        wait_scl_high();
        check_eq("R5 rx_valid cleared", {31'd0, rx_valid}, 0);
        repeat (HP/2) @(negedge clk);
        check_eq("R4 stretched byte acked", {31'd0, sda_bus}, 0);
        repeat (HP/2) @(negedge clk);
        scl_drv = 1'b0; repeat (4) @(negedge clk);
        bus_stop();

        // read, controller acks then nacks
        tx_push(8'h96); tx_push(8'h5B);
        bus_start();
        send_byte({7'h5A, 1'b1}, ack);
        check_eq("R2 address+read acked", {31'd0, ack}, 0);
        recv_byte(1'b0, d);
        check_eq("R6 read byte 1", {24'd0, d}, 32'h96);
        recv_byte(1'b1, d);
        check_eq("R7 read byte 2", {24'd0, d}, 32'h5B);
        half(); half();
        check_eq("R7 sda released after nack", {31'd0, sda_oe}, 0);
        check_eq("R7 no further load", tx_rd, 2);
        bus_stop();

        // read with stretch
        tx_en = 1'b0;
        tx_push(8'hE1);
        bus_start();
        send_byte({7'h5A, 1'b1}, ack);
        sda_drv = 1'b1; half();
        scl_drv = 1'b1;
        repeat (200) @(negedge clk);
        check_eq("R6 clock held low", {31'd0, scl_bus}, 0);
        check_eq("R6 no load before ready", tx_rd, 2);
        tx_en = 1'b1;
        wait_scl_high();
        repeat (HP/2) @(negedge clk);
        d[7] = sda_bus;
        repeat (HP/2) @(negedge clk);
        scl_drv = 1'b0; repeat (4) @(negedge clk);
        for (int i = 6; i >= 0; i--) begin
            clock_bit(1'b1, r);
            d[i] = r;
        end
        clock_bit(1'b1, r);
        check_eq("R6 stretched read byte", {24'd0, d}, 32'hE1);
        bus_stop();

        // repeated starts between bytes
        tx_push(8'h3F);
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        write_exp(8'h42, "R4 byte before restart");
        bus_start();
        send_byte({7'h5A, 1'b1}, ack);
        check_eq("R8 restart read acked", {31'd0, ack}, 0);
        recv_byte(1'b1, d);
        check_eq("R8 read after restart", {24'd0, d}, 32'h3F);
        bus_start();
        send_byte({7'h5B, 1'b0}, ack);
        check_eq("R8 restart foreign nack", {31'd0, ack}, 1);
        bus_stop();

        // repeated start within a byte
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b1, r);
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check_eq("R8 mid-byte restart acked", {31'd0, ack}, 0);
        write_exp(8'h81, "R8 byte after mid-byte restart");
        bus_stop();

        // stop within a byte
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        clock_bit(1'b0, r); clock_bit(1'b1, r); clock_bit(1'b0, r);
        bus_stop();
        check_eq("R9 sda idle after early stop", {31'd0, sda_oe}, 0);
        check_eq("R9 scl idle after early stop", {31'd0, scl_oe}, 0);

        // new own address
        dev_addr = 7'h13;
        bus_start();
        send_byte({7'h5A, 1'b0}, ack);
        check_eq("R3 old address now nacked", {31'd0, ack}, 1);
        bus_start();
        send_byte({7'h13, 1'b0}, ack);
        check_eq("R3 new address acked", {31'd0, ack}, 0);
        write_exp(8'h0F, "R4 byte to new address");
        bus_stop();

        repeat (20) @(negedge clk);
        check_eq("R4 all bytes delivered", exp_rx.size(), 0);
        check_eq("R10 sda steady while clock high", viol, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule